// File: doc/BRIEF.md
# Colour Lookup Table with Overlay Bank

The block holds an indexed colour palette of 256 normal entries plus a small overlay bank of four entries, each entry carrying an 8-bit red, green and blue component. Software loads and inspects the palette through a narrow register port. The port keeps a current entry index and a colour phase counter, so one colour is moved as three single-byte accesses. After the blue byte the index steps to the next entry, so a whole palette streams in with one index load.

The scan-out side presents 8-bit pixel indices on a valid/ready stream and receives the matching 24-bit colour on a second valid/ready stream one clock later. A pixel index is taken on any cycle where `pix_valid` and `pix_ready` are both high. `pix_ready` is high whenever the output stage is empty or the consumer takes the held colour in the same cycle. While `rgb_valid` is high and `rgb_ready` is low, the output colour is held unchanged and no new index is taken. Two overlay entries are driven continuously as cursor background and foreground colours.

Top module: `clut_top`

## Requirements
- R1: A write at byte offset 0 sets the current index to `wr_data[31:24]` and returns the phase to red.
- R2: Writes at offset 4 store `wr_data[31:24]` into the red, green and blue component of normal entry `index`, in that order on successive accesses.
- R3: The access that handles blue steps the index by one modulo 256 (255 wraps to 0) and returns the phase to red.
- R4: Writes at offset 12 follow the same phase sequence and index stepping, but store into overlay entry 256 + (index mod 4). Normal entries are left untouched.
- R5: A read (`rd_en` with `wr_en` low) returns the current-phase component of normal entry `index` in `rd_data[31:24]`, with zeros below, and raises `rd_valid` on the following clock. It steps the phase and index exactly as a write does.
- R6: After reset every entry is black except entries 255, 256 and 258, which are white (all components 0xFF). The index and phase are zero.
- R7: A write at any offset other than 0, 4 and 12 changes no entry, no index and no phase.
- R8: An accepted pixel index yields `rgb_data` = {red[23:16], green[15:8], blue[7:0]} of that normal entry, with `rgb_valid` high, one clock after acceptance.
- R9: While `rgb_valid` is high and `rgb_ready` is low, `pix_ready` is low and `rgb_data` stays stable.
- R10: `ovl_bg` shows overlay entry 258 and `ovl_fg` shows overlay entry 259 as {R,G,B}, updated the clock after a write to them.
- R11: A register write and a lookup of the same entry in the same cycle give the lookup the value from before the write.
- R12: When `wr_en` and `rd_en` are high together, the write is performed and the read is dropped (`rd_valid` stays low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_off | input | 4 | Register byte offset |
| wr_data | input | 32 | Write data, byte in bits 31:24 |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 32 | Read data, component in bits 31:24 |
| rd_valid | output | 1 | Read data valid, one clock after `rd_en` |
| pix_valid | input | 1 | Pixel index valid |
| pix_ready | output | 1 | Pixel index accepted when high with `pix_valid` |
| pix_idx | input | 8 | Pixel index |
| rgb_valid | output | 1 | Colour output valid |
| rgb_ready | input | 1 | Consumer takes colour |
| rgb_data | output | 24 | Colour {R,G,B} |
| ovl_bg | output | 24 | Overlay entry 258 colour |
| ovl_fg | output | 24 | Overlay entry 259 colour |

## Verification
The hardest state to reach from the ports is a component write and a lookup of the same entry landing on one clock edge. The bench gets there by loading the index, writing red and green, and then driving the blue write together with a lookup. The lookup must see the red and green bytes and an old blue byte of zero. Index wrap at 255 and the overlay alias (index mod 4) are reached through index loads placed just before the boundary. Ignored offsets are shown to have no effect by following them with a full colour write whose result would shift phase if they had counted.

// File: rtl/clut_pkg.sv
package clut_pkg;
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_t;

  localparam int NUM_COMP = 3;
endpackage

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int N_OVL  = 4,
  parameter logic [ADDR_W-1:0] OFF_INDEX = 4'd0,
  parameter logic [ADDR_W-1:0] OFF_NORM  = 4'd4,
  parameter logic [ADDR_W-1:0] OFF_OVL   = 4'd12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_off,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       rd_en,
  output logic [IDX_W-1:0]           cur_idx,
  output phase_t                     cur_ph,
  output logic                       st_wr,
  output logic [$clog2((1<<IDX_W)+N_OVL)-1:0] st_ent,
  output logic [COMP_W-1:0]          st_byte,
  output logic                       st_rd
);
  localparam int N_ENT = (1 << IDX_W) + N_OVL;
  localparam int ENT_W = $clog2(N_ENT);
  localparam int OVL_W = $clog2(N_OVL);
  localparam logic [ENT_W-1:0] OVL_BASE = ENT_W'(1 << IDX_W);

  logic do_idx, do_norm, do_ovl, advance;

  assign do_idx  = wr_en && (wr_off == OFF_INDEX);
  assign do_norm = wr_en && (wr_off == OFF_NORM);
  assign do_ovl  = wr_en && (wr_off == OFF_OVL);
  assign st_rd   = rd_en && !wr_en;
  assign advance = do_norm || do_ovl || st_rd;

  assign st_wr   = do_norm || do_ovl;
  assign st_byte = wr_data[DATA_W-1 -: COMP_W];
  assign st_ent  = do_ovl ? (OVL_BASE + ENT_W'(cur_idx[OVL_W-1:0]))
                          : ENT_W'(cur_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_idx <= '0;
      cur_ph  <= PH_RED;
    end else if (do_idx) begin
      cur_idx <= wr_data[DATA_W-1 -: IDX_W];
      cur_ph  <= PH_RED;
    end else if (advance) begin
      unique case (cur_ph)
        PH_RED:  cur_ph <= PH_GRN;
        PH_GRN:  cur_ph <= PH_BLU;
        default: begin
          cur_ph  <= PH_RED;
          cur_idx <= cur_idx + 1'b1;
        end
      endcase
    end
  end

  p_idx_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_off == OFF_INDEX) |=>
      (cur_idx == $past(wr_data[DATA_W-1 -: IDX_W]) && cur_ph == PH_RED));

  p_phase_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cur_ph != phase_t'(2'd3));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && cur_ph == PH_BLU) |=>
      (cur_ph == PH_RED && cur_idx == $past(cur_idx) + 1'b1));

  p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_off != OFF_INDEX && wr_off != OFF_NORM && wr_off != OFF_OVL)
      |=> ($stable(cur_idx) && $stable(cur_ph)));
endmodule

// File: rtl/clut_store.sv
module clut_store
  import clut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8,
  parameter int DATA_W = 32,
  parameter int N_OVL  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       st_wr,
  input  logic [$clog2((1<<IDX_W)+N_OVL)-1:0] st_ent,
  input  phase_t                     st_ph,
  input  logic [COMP_W-1:0]          st_byte,
  input  logic                       st_rd,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       rd_valid,
  input  logic [IDX_W-1:0]           lk_idx,
  output logic [NUM_COMP*COMP_W-1:0] lk_rgb,
  output logic [NUM_COMP*COMP_W-1:0] ovl_bg,
  output logic [NUM_COMP*COMP_W-1:0] ovl_fg
);
  localparam int N_ENT = (1 << IDX_W) + N_OVL;
  localparam int ENT_W = $clog2(N_ENT);
  localparam int WHITE_A = (1 << IDX_W) - 1;
  localparam int WHITE_B = (1 << IDX_W);
  localparam int WHITE_C = (1 << IDX_W) + 2;
  localparam logic [ENT_W-1:0] BG_ENT = ENT_W'((1 << IDX_W) + 2);
  localparam logic [ENT_W-1:0] FG_ENT = ENT_W'((1 << IDX_W) + 3);

  logic [COMP_W-1:0] lk_part [NUM_COMP];
  logic [COMP_W-1:0] rd_part [NUM_COMP];
  logic [COMP_W-1:0] bg_part [NUM_COMP];
  logic [COMP_W-1:0] fg_part [NUM_COMP];

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_plane
    logic [COMP_W-1:0] mem [N_ENT];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < N_ENT; i++) begin
          mem[i] <= (i == WHITE_A || i == WHITE_B || i == WHITE_C) ? '1 : '0;
        end
      end else if (st_wr && st_ph == phase_t'(2'(c))) begin
        mem[st_ent] <= st_byte;
      end
    end

    assign lk_part[c] = mem[ENT_W'(lk_idx)];
    assign rd_part[c] = mem[ENT_W'(rd_idx)];
    assign bg_part[c] = mem[BG_ENT];
    assign fg_part[c] = mem[FG_ENT];
  end

  assign lk_rgb = {lk_part[0], lk_part[1], lk_part[2]};
  assign ovl_bg = {bg_part[0], bg_part[1], bg_part[2]};
  assign ovl_fg = {fg_part[0], fg_part[1], fg_part[2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= st_rd;
      if (st_rd) rd_data <= {rd_part[st_ph], {(DATA_W-COMP_W){1'b0}}};
    end
  end

  p_rd_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_data[DATA_W-COMP_W-1:0] == '0));
endmodule

// File: rtl/clut_pipe.sv
module clut_pipe
  import clut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pix_valid,
  output logic                       pix_ready,
  input  logic [IDX_W-1:0]           pix_idx,
  output logic [IDX_W-1:0]           tbl_idx,
  input  logic [NUM_COMP*COMP_W-1:0] tbl_rgb,
  output logic                       rgb_valid,
  input  logic                       rgb_ready,
  output logic [NUM_COMP*COMP_W-1:0] rgb_data
);
  logic take;

  assign pix_ready = !rgb_valid || rgb_ready;
  assign take      = pix_valid && pix_ready;
  assign tbl_idx   = pix_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgb_valid <= 1'b0;
      rgb_data  <= '0;
    end else if (take) begin
      rgb_valid <= 1'b1;
      rgb_data  <= tbl_rgb;
    end else if (rgb_ready) begin
      rgb_valid <= 1'b0;
    end
  end

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready) |=> (rgb_valid && rgb_data == $past(tbl_rgb)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rgb_valid && !rgb_ready) |=> (rgb_valid && $stable(rgb_data)));
endmodule

// File: rtl/clut_top.sv
module clut_top
  import clut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int N_OVL  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_off,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       rd_en,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       rd_valid,
  input  logic                       pix_valid,
  output logic                       pix_ready,
  input  logic [IDX_W-1:0]           pix_idx,
  output logic                       rgb_valid,
  input  logic                       rgb_ready,
  output logic [NUM_COMP*COMP_W-1:0] rgb_data,
  output logic [NUM_COMP*COMP_W-1:0] ovl_bg,
  output logic [NUM_COMP*COMP_W-1:0] ovl_fg
);
  localparam int N_ENT = (1 << IDX_W) + N_OVL;
  localparam int ENT_W = $clog2(N_ENT);
  localparam int RGB_W = NUM_COMP * COMP_W;

  logic [IDX_W-1:0]  cur_idx;
  phase_t            cur_ph;
  logic              st_wr, st_rd;
  logic [ENT_W-1:0]  st_ent;
  logic [COMP_W-1:0] st_byte;
  logic [IDX_W-1:0]  tbl_idx;
  logic [RGB_W-1:0]  tbl_rgb;

  clut_seq #(
    .IDX_W(IDX_W), .COMP_W(COMP_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .N_OVL(N_OVL)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data), .rd_en(rd_en),
    .cur_idx(cur_idx), .cur_ph(cur_ph),
    .st_wr(st_wr), .st_ent(st_ent), .st_byte(st_byte), .st_rd(st_rd)
  );

  clut_store #(
    .IDX_W(IDX_W), .COMP_W(COMP_W), .DATA_W(DATA_W), .N_OVL(N_OVL)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .st_wr(st_wr), .st_ent(st_ent), .st_ph(cur_ph), .st_byte(st_byte),
    .st_rd(st_rd), .rd_idx(cur_idx),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .lk_idx(tbl_idx), .lk_rgb(tbl_rgb),
    .ovl_bg(ovl_bg), .ovl_fg(ovl_fg)
  );

  clut_pipe #(
    .IDX_W(IDX_W), .COMP_W(COMP_W)
  ) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_idx(pix_idx),
    .tbl_idx(tbl_idx), .tbl_rgb(tbl_rgb),
    .rgb_valid(rgb_valid), .rgb_ready(rgb_ready), .rgb_data(rgb_data)
  );

  p_collide_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |=> !rd_valid);
endmodule

// File: tb/sim_clut_top.sv
module sim_clut_top;
  localparam int NV = 43;
  localparam logic [1:0] WR = 2'd0, RD = 2'd1, LK = 2'd2;

  // vector: {op[41:40], req[39:36], off[35:32], dat[31:24], exp[23:0]}
  localparam logic [41:0] VEC [NV] = '{
    {LK, 4'd6, 4'h0, 8'hFF, 24'hFFFFFF},  // R6 entry 255 white
    {LK, 4'd6, 4'h0, 8'h00, 24'h000000},  // R6 entry 0 black
    {WR, 4'd1, 4'h0, 8'h10, 24'h0},       // R1 index 0x10
    {WR, 4'd2, 4'h4, 8'h11, 24'h0},       // R2
    {WR, 4'd2, 4'h4, 8'h22, 24'h0},
    {WR, 4'd2, 4'h4, 8'h33, 24'h0},
    {WR, 4'd3, 4'h4, 8'h44, 24'h0},       // R3 next entry
    {WR, 4'd3, 4'h4, 8'h55, 24'h0},
    {WR, 4'd3, 4'h4, 8'h66, 24'h0},
    {LK, 4'd8, 4'h0, 8'h10, 24'h112233},  // R8
    {LK, 4'd3, 4'h0, 8'h11, 24'h445566},  // R3
    {WR, 4'd1, 4'h0, 8'h10, 24'h0},
    {RD, 4'd5, 4'h0, 8'h00, 24'h11},      // R5
    {RD, 4'd5, 4'h0, 8'h00, 24'h22},
    {RD, 4'd5, 4'h0, 8'h00, 24'h33},
    {RD, 4'd5, 4'h0, 8'h00, 24'h44},
    {WR, 4'd1, 4'h0, 8'hFF, 24'h0},
    {WR, 4'd3, 4'h4, 8'h01, 24'h0},
    {WR, 4'd3, 4'h4, 8'h02, 24'h0},
    {WR, 4'd3, 4'h4, 8'h03, 24'h0},       // R3 wraps to 0
    {WR, 4'd3, 4'h4, 8'hA0, 24'h0},
    {WR, 4'd3, 4'h4, 8'hA1, 24'h0},
    {WR, 4'd3, 4'h4, 8'hA2, 24'h0},
    {LK, 4'd3, 4'h0, 8'hFF, 24'h010203},
    {LK, 4'd3, 4'h0, 8'h00, 24'hA0A1A2},
    {WR, 4'd1, 4'h0, 8'h20, 24'h0},
    {WR, 4'd7, 4'h8, 8'h99, 24'h0},       // R7 ignored offset
    {WR, 4'd7, 4'h4, 8'h77, 24'h0},
    {WR, 4'd7, 4'h4, 8'h88, 24'h0},
    {WR, 4'd7, 4'h4, 8'h99, 24'h0},
    {LK, 4'd7, 4'h0, 8'h20, 24'h778899},
    {WR, 4'd4, 4'h0, 8'h06, 24'h0},       // R4 6 mod 4 = 2 -> 258
    {WR, 4'd4, 4'hC, 8'h12, 24'h0},
    {WR, 4'd4, 4'hC, 8'h34, 24'h0},
    {WR, 4'd4, 4'hC, 8'h56, 24'h0},
    {WR, 4'd4, 4'hC, 8'h9A, 24'h0},       // index 7 -> 259
    {WR, 4'd4, 4'hC, 8'hBC, 24'h0},
    {WR, 4'd4, 4'hC, 8'hDE, 24'h0},
    {LK, 4'd4, 4'h0, 8'h06, 24'h000000},  // R4 normal entry untouched
    {WR, 4'd4, 4'h4, 8'hAA, 24'h0},
    {WR, 4'd4, 4'h4, 8'hBB, 24'h0},
    {WR, 4'd4, 4'h4, 8'hCC, 24'h0},
    {LK, 4'd4, 4'h0, 8'h08, 24'hAABBCC}   // R4 index stepped to 8
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, pix_valid = 1'b0, rgb_ready = 1'b1;
  logic [3:0]  wr_off = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  pix_idx = '0;
  logic [31:0] rd_data;
  logic        rd_valid, pix_ready, rgb_valid;
  logic [23:0] rgb_data, ovl_bg, ovl_fg;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clut_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_idx(pix_idx),
    .rgb_valid(rgb_valid), .rgb_ready(rgb_ready), .rgb_data(rgb_data),
    .ovl_bg(ovl_bg), .ovl_fg(ovl_fg)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(logic [3:0] off, logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_off = off; wr_data = {b, 24'h5A5A5A};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(string tag, logic [7:0] b);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk({tag, " rd_valid"}, {31'd0, rd_valid}, 32'd1);
    chk(tag, rd_data, {b, 24'h0});
  endtask

  task automatic do_lk(string tag, logic [7:0] idx, logic [23:0] exp);
    @(negedge clk);
    pix_valid = 1'b1; pix_idx = idx;
    @(negedge clk);
    pix_valid = 1'b0;
    chk({tag, " rgb_valid"}, {31'd0, rgb_valid}, 32'd1);
    chk(tag, {8'h0, rgb_data}, {8'h0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R6 reset state at the ports
    chk("R6 ovl_bg", {8'h0, ovl_bg}, 32'h00FFFFFF);
    chk("R6 ovl_fg", {8'h0, ovl_fg}, 32'h0);
    chk("R6 rgb_valid", {31'd0, rgb_valid}, 32'd0);
    do_rd("R6 index0 red", 8'h00);
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i][39:36], i);
      case (VEC[i][41:40])
        WR: do_wr(VEC[i][35:32], VEC[i][31:24]);
        RD: do_rd(tag, VEC[i][7:0]);
        default: do_lk(tag, VEC[i][31:24], VEC[i][23:0]);
      endcase
    end
    chk("R10 ovl_bg", {8'h0, ovl_bg}, 32'h00123456);
    chk("R10 ovl_fg", {8'h0, ovl_fg}, 32'h009ABCDE);

    // R9 back-pressure
    @(negedge clk);
    rgb_ready = 1'b0; pix_valid = 1'b1; pix_idx = 8'h10;
    @(negedge clk);
    chk("R9 pix_ready low", {31'd0, pix_ready}, 32'd0);
    chk("R9 first colour", {8'h0, rgb_data}, 32'h00112233);
    pix_idx = 8'h11;
    @(negedge clk);
    chk("R9 held colour", {8'h0, rgb_data}, 32'h00112233);
    chk("R9 held valid", {31'd0, rgb_valid}, 32'd1);
    rgb_ready = 1'b1;
    @(negedge clk);
    pix_valid = 1'b0;
    chk("R9 next colour", {8'h0, rgb_data}, 32'h00445566);

    // R11 write and lookup on the same edge
    do_wr(4'h0, 8'h30);
    do_wr(4'h4, 8'h5A);
    do_wr(4'h4, 8'h5B);
    @(negedge clk);
    wr_en = 1'b1; wr_off = 4'h4; wr_data = {8'h5C, 24'h0};
    pix_valid = 1'b1; pix_idx = 8'h30;
    @(negedge clk);
    wr_en = 1'b0; pix_valid = 1'b0;
    chk("R11 old value", {8'h0, rgb_data}, 32'h005A5B00);
    do_lk("R11 new value", 8'h30, 24'h5A5B5C);

    // R12 write and read together
    do_wr(4'h0, 8'h40);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; wr_off = 4'h4; wr_data = {8'hD1, 24'h0};
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R12 read dropped", {31'd0, rd_valid}, 32'd0);
    do_wr(4'h4, 8'hD2);
    do_wr(4'h4, 8'hD3);
    do_lk("R12 write kept", 8'h40, 24'hD1D2D3);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule